// File: doc/BRIEF.md
# Buffered Page Program Controller

This block sits behind the serial front end of a small nonvolatile memory and turns a stream of write bytes into one timed program operation. A write command opens with a start strobe that carries the target byte address, the state of the write-enable latch and the protection verdict for that address. The data bytes that follow go into a page buffer rather than straight into the array. The buffer column starts at the low address bits and advances by one for each byte. When it passes the end of the page it wraps back to the start of the same page, so a later byte replaces an earlier one.

The array is touched only when the front end reports that the chip has been deselected. If a whole number of bytes was received, at least one byte is present, the enable latch was set and the address was not protected, the block raises its busy flag for a fixed number of system clocks and writes the loaded buffer slots into the array during that window. When the window ends it emits a one-cycle completion pulse, which the status logic uses to clear the enable latch. While busy, the block ignores new write commands, write bytes, deselect strobes and array read requests. A small read port lets the front end fetch array bytes when no program cycle is running.

Top module: `page_write_engine`

## Requirements
- R1: After reset, `busy`, `cycle_done` and `rd_ack` are 0, and every array byte reads as 0x00.
- R2: A command that is committed writes its k-th data byte (k from 0) to the address whose upper bits equal the upper bits of `cmd_addr` and whose low log2(PAGE_BYTES) bits equal (`cmd_addr` low bits + k) mod PAGE_BYTES.
- R3: When more than PAGE_BYTES data bytes arrive, the later bytes replace the earlier ones in the same page. Page slots that received no byte keep their old contents.
- R4: A `cs_rise` during a command, with `cs_partial`=0, at least one byte received, `cmd_wel`=1 and `cmd_blocked`=0, makes `busy` read 1 from the next cycle. `busy` then stays 1 for exactly CYCLE_CLKS cycles.
- R5: `cycle_done` is 1 for exactly one cycle: the first cycle in which `busy` reads 0 again. This is the latch-clear pulse.
- R6: A `cs_rise` with `cs_partial`=1 ends the command without a program cycle, and the array is left unchanged.
- R7: A command whose start had `cmd_blocked`=1 or `cmd_wel`=0 gives no program cycle and leaves the array unchanged.
- R8: While `busy` is 1, `cmd_start`, `byte_valid` and `cs_rise` have no effect. The running cycle is not lengthened, and no byte sent during it reaches the array.
- R9: A `rd_req` while `busy` is 0 gives `rd_ack`=1 and the addressed array byte on `rd_data` in the next cycle. A `rd_req` while `busy` is 1 gives `rd_ack`=0.
- R10: A `cs_rise` with no data byte received since the command start gives no program cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Write command start strobe |
| cmd_addr | input | ADDR_W | Start byte address of the command |
| cmd_wel | input | 1 | Write-enable latch state at command start |
| cmd_blocked | input | 1 | Protection verdict for the command address |
| byte_valid | input | 1 | One data byte present on `byte_data` |
| byte_data | input | 8 | Data byte |
| cs_rise | input | 1 | Chip-deselect strobe |
| cs_partial | input | 1 | Deselect came partway through a byte |
| busy | output | 1 | Program cycle in progress |
| cycle_done | output | 1 | One-cycle pulse when the program cycle ends |
| rd_req | input | 1 | Array read request |
| rd_addr | input | ADDR_W | Array read address |
| rd_ack | output | 1 | Read data valid |
| rd_data | output | 8 | Array read data |

## Verification
Every cycle, the embedded assertions check these things: the cycle counter stays inside its window, the completion pulse lasts one cycle and follows the fall of busy, array writes happen only while busy, a read acknowledge never follows a busy cycle, busy rises only after a clean deselect, and a cleared buffer is empty. Some behaviour shows only in the bench's scenarios, because it needs a reference image of the array. This covers where each byte lands after column wraparound, that aborted, blocked or unenabled commands and traffic during busy leave the array unchanged, and that busy lasts exactly the configured number of clocks.

// File: rtl/pwe_pkg.sv
package pwe_pkg;

    typedef enum logic {
        PW_IDLE    = 1'b0,
        PW_COLLECT = 1'b1
    } pw_state_t;

    typedef struct packed {
        logic wel;
        logic blocked;
    } pw_grant_t;

    function automatic logic grant_ok(input pw_grant_t g);
        return g.wel && !g.blocked;
    endfunction

endpackage

// File: rtl/pwe_page_buffer.sv
module pwe_page_buffer #(
    parameter int PAGE_BYTES = 32,
    localparam int COL_W = $clog2(PAGE_BYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic [COL_W-1:0] col_init,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic [COL_W-1:0] rd_idx,
    output logic [7:0]       rd_byte,
    output logic             rd_loaded,
    output logic             any_loaded
);

    logic [7:0]            slot [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] loaded;
    logic [COL_W-1:0]      col;

    always_ff @(posedge clk) begin
        if (rst) begin
            loaded <= '0;
            col    <= '0;
        end else if (clear) begin
            loaded <= '0;
            col    <= col_init;
        end else if (wr_en) begin
            loaded[col] <= 1'b1;
            col         <= col + 1'b1;
        end
    end

    generate
        for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst)
                    slot[i] <= '0;
                else if (!clear && wr_en && col == COL_W'(i))
                    slot[i] <= wr_data;
            end
        end
    endgenerate

    assign rd_byte    = slot[rd_idx];
    assign rd_loaded  = loaded[rd_idx];
    assign any_loaded = |loaded;

    a_r3_clear_empties: assert property (@(posedge clk) disable iff (rst)
        clear |=> !any_loaded);

endmodule

// File: rtl/pwe_cycle_timer.sv
module pwe_cycle_timer #(
    parameter int CYCLE_CLKS = 64,
    localparam int CNT_W = $clog2(CYCLE_CLKS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             running,
    output logic [CNT_W-1:0] cnt,
    output logic             done
);

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            cnt     <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !running) begin
                running <= 1'b1;
                cnt     <= '0;
            end else if (running) begin
                if (cnt == CNT_W'(CYCLE_CLKS - 1)) begin
                    running <= 1'b0;
                    done    <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    a_r4_cnt_window: assert property (@(posedge clk) disable iff (rst)
        running |-> (cnt < CNT_W'(CYCLE_CLKS)));

    a_r5_done_after_run: assert property (@(posedge clk) disable iff (rst)
        done |-> (!running && $past(running)));

    a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/pwe_array.sv
module pwe_array #(
    parameter int ADDR_W = 10,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic              rvalid,
    output logic [7:0]        rdata
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= re;
            if (re) rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/page_write_engine.sv
module page_write_engine
    import pwe_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int PAGE_BYTES = 32,
    parameter int CYCLE_CLKS = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_start,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              cmd_wel,
    input  logic              cmd_blocked,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    input  logic              cs_rise,
    input  logic              cs_partial,
    output logic              busy,
    output logic              cycle_done,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_ack,
    output logic [7:0]        rd_data
);

    localparam int COL_W  = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - COL_W;
    localparam int CNT_W  = $clog2(CYCLE_CLKS + 1);

    pw_state_t         state;
    pw_grant_t         grant;
    logic [PAGE_W-1:0] page_q;

    logic              take_cmd;
    logic              take_byte;
    logic              go;
    logic              slot_loaded;
    logic              any_loaded;
    logic [7:0]        slot_byte;
    logic [CNT_W-1:0]  tcnt;
    logic [COL_W-1:0]  commit_idx;
    logic              arr_we;

    assign take_cmd  = cmd_start && !busy;
    assign take_byte = byte_valid && state == PW_COLLECT && !busy && !cmd_start;
    assign go        = state == PW_COLLECT && cs_rise && !cs_partial && !cmd_start
                       && any_loaded && grant_ok(grant);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= PW_IDLE;
            grant  <= '0;
            page_q <= '0;
        end else if (take_cmd) begin
            state         <= PW_COLLECT;
            grant.wel     <= cmd_wel;
            grant.blocked <= cmd_blocked;
            page_q        <= cmd_addr[ADDR_W-1:COL_W];
        end else if (state == PW_COLLECT && cs_rise) begin
            state <= PW_IDLE;
        end
    end

    assign commit_idx = tcnt[COL_W-1:0];
    assign arr_we     = busy && (tcnt < CNT_W'(PAGE_BYTES)) && slot_loaded;

    pwe_page_buffer #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
        .clk        (clk),
        .rst        (rst),
        .clear      (take_cmd),
        .col_init   (cmd_addr[COL_W-1:0]),
        .wr_en      (take_byte),
        .wr_data    (byte_data),
        .rd_idx     (commit_idx),
        .rd_byte    (slot_byte),
        .rd_loaded  (slot_loaded),
        .any_loaded (any_loaded)
    );

    pwe_cycle_timer #(.CYCLE_CLKS(CYCLE_CLKS)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .start   (go),
        .running (busy),
        .cnt     (tcnt),
        .done    (cycle_done)
    );

    pwe_array #(.ADDR_W(ADDR_W)) u_array (
        .clk    (clk),
        .rst    (rst),
        .we     (arr_we),
        .waddr  ({page_q, commit_idx}),
        .wdata  (slot_byte),
        .re     (rd_req && !busy),
        .raddr  (rd_addr),
        .rvalid (rd_ack),
        .rdata  (rd_data)
    );

    a_r2_write_only_busy: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> busy);

    a_r9_ack_not_busy: assert property (@(posedge clk) disable iff (rst)
        rd_ack |-> !$past(busy));

    a_r6_clean_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(cs_rise && !cs_partial));

    a_r8_busy_holds_state: assert property (@(posedge clk) disable iff (rst)
        busy |-> state == PW_IDLE || $past(busy) == 1'b0);

endmodule

// File: tb/sim_page_write_engine.sv
module sim_page_write_engine;

    localparam int CLK_PERIOD = 10;
    localparam int AW   = 10;
    localparam int PG   = 32;
    localparam int CYC  = 40;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_start = 0, cmd_wel = 0, cmd_blocked = 0;
    logic [AW-1:0] cmd_addr = '0;
    logic byte_valid = 0;
    logic [7:0] byte_data = '0;
    logic cs_rise = 0, cs_partial = 0;
    logic busy, cycle_done, rd_req = 0, rd_ack;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0] rd_data;

    int n_chk = 0, n_fail = 0;
    logic [7:0] model [DEPTH];
    logic [7:0] pend [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    page_write_engine #(.ADDR_W(AW), .PAGE_BYTES(PG), .CYCLE_CLKS(CYC)) u0 (
        .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_addr(cmd_addr),
        .cmd_wel(cmd_wel), .cmd_blocked(cmd_blocked), .byte_valid(byte_valid),
        .byte_data(byte_data), .cs_rise(cs_rise), .cs_partial(cs_partial),
        .busy(busy), .cycle_done(cycle_done), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_ack(rd_ack), .rd_data(rd_data)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int dest_addr(input int start, input int k);
        return (start / PG) * PG + ((start % PG) + k) % PG;
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_read(input int a, output logic ack, output logic [7:0] d);
        rd_req = 1; rd_addr = AW'(a);
        tick();
        rd_req = 0;
        ack = rd_ack; d = rd_data;
    endtask

    task automatic check_page(input int a, input string req);
        logic ack; logic [7:0] d;
        int base = (a / PG) * PG;
        for (int i = 0; i < PG; i++) begin
            do_read(base + i, ack, d);
            chk(ack === 1'b1 && d === model[base + i], req, int'(d), int'(model[base + i]));
        end
    endtask

    // one full command; returns after the cycle (if any) has ended
    task automatic run_cmd(input int a, input int n, input logic wel, input logic blk,
                           input logic part, input string req);
        int len;
        logic expect_go;
        cmd_start = 1; cmd_addr = AW'(a); cmd_wel = wel; cmd_blocked = blk;
        tick();
        cmd_start = 0;
        for (int k = 0; k < n; k++) begin
            byte_valid = 1; byte_data = pend[k];
            tick();
        end
        byte_valid = 0;
        cs_rise = 1; cs_partial = part;
        tick();
        cs_rise = 0; cs_partial = 0;
        expect_go = (n > 0) && wel && !blk && !part;
        if (expect_go) begin
            for (int k = 0; k < n; k++) model[dest_addr(a, k)] = pend[k];
            len = 0;
            while (busy === 1'b1 && len < CYC + 10) begin
                chk(cycle_done === 1'b0, "R5 done low while busy", int'(cycle_done), 0);
                len++;
                tick();
            end
            chk(len == CYC, {req, " R4 busy length"}, len, CYC);
            chk(cycle_done === 1'b1, "R5 done after busy", int'(cycle_done), 1);
            tick();
            chk(cycle_done === 1'b0, "R5 done single cycle", int'(cycle_done), 0);
        end else begin
            chk(busy === 1'b0, {req, " no program cycle"}, int'(busy), 0);
            tick();
            chk(busy === 1'b0 && cycle_done === 1'b0, {req, " stays idle"}, int'(busy), 0);
        end
    endtask

    initial begin
        logic ack; logic [7:0] d;
        int len;
        void'($urandom(32'd20240611));
        for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
        repeat (3) tick();
        rst = 0;
        tick();
        // R1
        chk(busy === 0 && cycle_done === 0 && rd_ack === 0, "R1 reset outputs", int'(busy), 0);
        do_read(5, ack, d);
        chk(ack === 1 && d === 8'h00, "R1 R9 array zero after reset", int'(d), 0);

        // R2 single byte at last column
        pend[0] = 8'hA5;
        run_cmd(63, 1, 1, 0, 0, "R2 single byte");
        check_page(63, "R2 single byte page");

        // R3 wraparound, 36 bytes starting at column 30
        for (int k = 0; k < 36; k++) pend[k] = 8'(8'h40 + k);
        run_cmd(128 + 30, 36, 1, 0, 0, "R3 wrap");
        check_page(128, "R3 wrap page content");

        // R3 partial page leaves others: preload then rewrite 3 bytes
        for (int k = 0; k < 3; k++) pend[k] = 8'(8'hC0 + k);
        run_cmd(128 + 10, 3, 1, 0, 0, "R3 partial page");
        check_page(128, "R3 untouched slots");

        // R6 partial final byte
        for (int k = 0; k < 4; k++) pend[k] = 8'hEE;
        run_cmd(128 + 10, 4, 1, 0, 1, "R6 partial abort");
        check_page(128, "R6 array unchanged");

        // R7 blocked and not enabled
        run_cmd(128, 4, 1, 1, 0, "R7 blocked");
        run_cmd(128, 4, 0, 0, 0, "R7 latch clear");
        check_page(128, "R7 array unchanged");

        // R10 no bytes
        run_cmd(256, 0, 1, 0, 0, "R10 zero bytes");

        // R8 and R9 during busy
        for (int k = 0; k < 2; k++) pend[k] = 8'(8'h11 * (k + 1));
        cmd_start = 1; cmd_addr = AW'(320); cmd_wel = 1; cmd_blocked = 0;
        tick(); cmd_start = 0;
        for (int k = 0; k < 2; k++) begin byte_valid = 1; byte_data = pend[k]; tick(); end
        byte_valid = 0; cs_rise = 1; tick(); cs_rise = 0;
        model[320] = pend[0]; model[321] = pend[1];
        len = 1;
        rd_req = 1; rd_addr = AW'(320); tick(); rd_req = 0; len++;
        chk(rd_ack === 1'b0, "R9 read ignored while busy", int'(rd_ack), 0);
        cmd_start = 1; cmd_addr = AW'(384); tick(); cmd_start = 0; len++;
        byte_valid = 1; byte_data = 8'h77; tick(); byte_valid = 0; len++;
        cs_rise = 1; tick(); cs_rise = 0; len++;
        while (busy === 1'b1 && len < CYC + 10) begin len++; tick(); end
        chk(len == CYC + 1, "R8 busy not lengthened", len - 1, CYC);
        tick();
        chk(busy === 1'b0, "R8 no second cycle", int'(busy), 0);
        check_page(320, "R8 committed page");
        check_page(384, "R8 ignored bytes absent");

        // random mix
        for (int t = 0; t < 30; t++) begin
            int a = int'($urandom_range(DEPTH - 1, 0));
            int n = int'($urandom_range(40, 0));
            logic wel = ($urandom_range(7, 0) != 0);
            logic blk = ($urandom_range(7, 0) == 0);
            logic part = ($urandom_range(7, 0) == 0);
            for (int k = 0; k < n; k++) pend[k] = 8'($urandom);
            run_cmd(a, n, wel, blk, part, "R2 random");
            check_page(a, "R2 R3 random page");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule